// File: doc/BRIEF.md
# Transactional Signature Conflict Detector

This block watches the memory accesses of two hardware threads that run speculative transactions and decides when the two transactions touch the same data in a way that cannot both stand. Each thread owns two bit vectors, one recording what it has loaded and one recording what it has stored during its current transaction. An address is turned into a one-hot or few-hot vector by a configurable hash. A new access is tested by a bitwise AND against the other thread's vectors followed by an OR-reduction. Because the vectors are lossy, two different addresses can map to the same bit. In that case a conflict is reported that did not really happen. This is allowed. A conflict that really happened is never missed.

The hash is chosen at build time. The first variant takes a group of low address bits directly as an index. The second splits the vector into equal parts and, for each part, XORs a slice of low address bits with a slice of high address bits. The third is a fixed set of address-bit predicates (leaves of a trie), each owning one bit. Starting, committing or aborting a transaction wipes that thread's two vectors in a single clock edge. The result is registered and names the thread that must roll back. Undo logging and the rollback itself are handled elsewhere.

Top module: `tm_sig_detector`

## Requirements
- R1: A load inside a transaction sets its hash bits only in that thread's read vector, and a store sets them only in that thread's write vector; bits once set stay set until the thread's vectors are cleared.
- R2: A load that overlaps only the other thread's read vector, or a load in the same cycle as the other thread's load, never raises a conflict.
- R3: A load overlapping the other thread's write vector, or a store overlapping either vector of the other thread, sets conflict_o in the cycle after the clock edge that samples the access, with abort_tid_o equal to the accessing thread; no such overlap is ever missed.
- R4: When both threads access in the same cycle with overlapping hash vectors and at least one is a store, both are flagged and abort_tid_o = 1 (thread 0 wins); whenever both threads are flagged in one cycle, thread 1 is named.
- R5: tx_begin_i, tx_commit_i or tx_abort_i for a thread clears both of its vectors at the next clock edge; begin marks the thread as being in a transaction, commit or abort ends it, and commit/abort win over begin in the same cycle.
- R6: An access by a thread that is not in a transaction, or that has begin, commit or abort in the same cycle, sets no bits and raises no conflict; a thread that commits or aborts in a cycle is not a conflict target in that cycle.
- R7: Bit-select hash (HASH_KIND = 0): the vector has exactly one bit set, at index addr[ADDR_LSB +: log2(SIG_BITS)]; two addresses sharing those bits alias and conflict.
- R8: XOR-fold hash (HASH_KIND = 1): the vector is split into NUM_HASH parts of SIG_BITS/NUM_HASH bits; part k sets one bit at index addr[ADDR_LSB + k*PW +: PW] XOR addr[ADDR_W-1 - k*PW -: PW], with PW = log2 of the part size; a single overlapping bit in any part is a conflict.
- R9: Trie hash (HASH_KIND = 2): leaf i sets vector bit i when (addr AND mask_i) equals match_i; the default leaves are bit 0 = A2 & A0, bit 1 = A2 & !A0, bit 2 = !A2, so each address sets exactly one bit.
- R10: During and right after reset conflict_o = 0, abort_tid_o = 0 and neither thread is in a transaction; in any cycle without a conflict abort_tid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid_i | input | 2 | Access valid, one bit per thread |
| acc_write_i | input | 2 | Per thread: 1 = store, 0 = load |
| acc_addr_i | input | 2 x ADDR_W (64) | Access address per thread, thread 1 in the upper word |
| tx_begin_i | input | 2 | Start a transaction, per thread |
| tx_commit_i | input | 2 | Commit the transaction, per thread |
| tx_abort_i | input | 2 | Abort the transaction, per thread |
| conflict_o | output | 1 | Registered conflict flag |
| abort_tid_o | output | 1 | Thread to roll back, valid when conflict_o is high |

## Verification
The assertions take for granted that the address and control inputs are known values whenever they are sampled, and that identical addresses hash to identical vectors, which the same-address tie property relies on. They also assume that the control inputs change only between clock edges. The stimulus meets these conditions by driving every input on the falling edge with defined values. It draws addresses from a small fixed pool that contains deliberate aliasing pairs for each hash. Begin, commit and abort pulses are mixed freely with accesses, so the clear-priority corners occur on their own.

// File: rtl/tmsig_pkg.sv
// Shared definitions for the transactional signature conflict detector.
// Assumes exactly two thread contexts; the thread-id width follows from that.
package tmsig_pkg;
    typedef enum logic [1:0] {
        HASH_BITSEL  = 2'd0,
        HASH_XORFOLD = 2'd1,
        HASH_TRIE    = 2'd2
    } hash_kind_e;

    localparam int NTHR  = 2;
    localparam int TID_W = $clog2(NTHR);
endpackage

// File: rtl/tmsig_hash.sv
// Address-to-signature hash. Purely combinational.
// KIND picks the variant at elaboration. Assumes SIG_BITS and SIG_BITS/NUM_HASH
// are powers of two and that the trie leaves partition the address space.
module tmsig_hash
    import tmsig_pkg::*;
#(
    parameter hash_kind_e KIND        = HASH_BITSEL,
    parameter int         ADDR_W      = 32,
    parameter int         SIG_BITS    = 64,
    parameter int         ADDR_LSB    = 2,
    parameter int         NUM_HASH    = 4,
    parameter int         TRIE_LEAVES = 3,
    parameter logic [TRIE_LEAVES*ADDR_W-1:0] TRIE_MASK  = {32'h4, 32'h5, 32'h5},
    parameter logic [TRIE_LEAVES*ADDR_W-1:0] TRIE_MATCH = {32'h0, 32'h4, 32'h5}
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [SIG_BITS-1:0] vec_o
);
    localparam int IDXW = $clog2(SIG_BITS);
    localparam int PART = SIG_BITS / NUM_HASH;
    localparam int PW   = $clog2(PART);

    // Some variants leave address bits unread; fold them here.
    logic unused_addr;
    assign unused_addr = ^addr_i;

    if (KIND == HASH_BITSEL) begin : g_bitsel
        logic [IDXW-1:0] idx;
        // Low address bits used directly as the bit index.
        assign idx   = addr_i[ADDR_LSB +: IDXW];
        assign vec_o = {{(SIG_BITS-1){1'b0}}, 1'b1} << idx;
    end else if (KIND == HASH_XORFOLD) begin : g_xor
        for (genvar k = 0; k < NUM_HASH; k++) begin : g_part
            logic [PW-1:0] idx;
            // Each part folds a low slice onto a high slice.
            assign idx = addr_i[ADDR_LSB + k*PW +: PW] ^ addr_i[ADDR_W-1 - k*PW -: PW];
            assign vec_o[k*PART +: PART] = {{(PART-1){1'b0}}, 1'b1} << idx;
        end
    end else begin : g_trie
        for (genvar i = 0; i < SIG_BITS; i++) begin : g_leaf
            if (i < TRIE_LEAVES) begin : g_used
                // Leaf predicate: masked address equals the leaf pattern.
                assign vec_o[i] = ((addr_i & TRIE_MASK[i*ADDR_W +: ADDR_W])
                                   == TRIE_MATCH[i*ADDR_W +: ADDR_W]);
            end else begin : g_spare
                assign vec_o[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmsig_thread_ctx.sv
// Per-thread transaction context: in-transaction flag plus read and write
// signatures. Assumes start/finish are single-cycle pulses; finish wins.
// An access counts only while in a transaction and not being cleared.
module tmsig_thread_ctx #(
    parameter int SIG_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                finish_i,
    input  logic                acc_valid_i,
    input  logic                acc_write_i,
    input  logic [SIG_BITS-1:0] vec_i,
    output logic                active_o,
    output logic                eff_o,
    output logic                clear_o,
    output logic [SIG_BITS-1:0] rd_sig_o,
    output logic [SIG_BITS-1:0] wr_sig_o
);
    logic                active_q;
    logic [SIG_BITS-1:0] rd_q, wr_q;

    assign clear_o  = start_i | finish_i;
    assign eff_o    = acc_valid_i & active_q & ~clear_o;
    assign active_o = active_q;
    assign rd_sig_o = rd_q;
    assign wr_sig_o = wr_q;

    // Track whether the thread is inside a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_q <= 1'b0;
        else if (finish_i) active_q <= 1'b0;
        else if (start_i)  active_q <= 1'b1;
    end

    // Accumulate hashed bits; wipe both vectors in one edge on any clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (eff_o) begin
            if (acc_write_i) wr_q <= wr_q | vec_i;
            else             rd_q <= rd_q | vec_i;
        end
    end
endmodule

// File: rtl/tmsig_conflict.sv
// Cross-thread conflict test and registered verdict.
// Tests each counted access against the other threads' stored vectors and
// against their same-cycle accesses. When several threads are flagged the
// highest-numbered one is named, so the lowest-numbered keeps running.
module tmsig_conflict
    import tmsig_pkg::*;
#(
    parameter int SIG_BITS = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NTHR-1:0]                    eff_i,
    input  logic [NTHR-1:0]                    write_i,
    input  logic [NTHR-1:0]                    clear_i,
    input  logic [NTHR-1:0][SIG_BITS-1:0]      vec_i,
    input  logic [NTHR-1:0][SIG_BITS-1:0]      rd_sig_i,
    input  logic [NTHR-1:0][SIG_BITS-1:0]      wr_sig_i,
    output logic                               conflict_o,
    output logic [TID_W-1:0]                   abort_tid_o
);
    logic [NTHR-1:0]  flag;
    logic [TID_W-1:0] tid_d;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic hit_c;
        // Any overlap with another thread's vectors or same-cycle access.
        always_comb begin
            hit_c = 1'b0;
            for (int o = 0; o < NTHR; o++) begin
                if (o != t) begin
                    if (!clear_i[o] &&
                        |(vec_i[t] & (write_i[t] ? (rd_sig_i[o] | wr_sig_i[o])
                                                 : wr_sig_i[o])))
                        hit_c = 1'b1;
                    if (eff_i[o] && (write_i[t] || write_i[o]) &&
                        |(vec_i[t] & vec_i[o]))
                        hit_c = 1'b1;
                end
            end
        end
        assign flag[t] = eff_i[t] & hit_c;
    end

    // Name the highest-numbered flagged thread.
    always_comb begin
        tid_d = '0;
        for (int t = 0; t < NTHR; t++)
            if (flag[t]) tid_d = TID_W'(t);
    end

    // Register the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict_o  <= 1'b0;
            abort_tid_o <= '0;
        end else begin
            conflict_o  <= |flag;
            abort_tid_o <= tid_d;
        end
    end
endmodule

// File: rtl/tm_sig_detector.sv
// Top of the transactional signature conflict detector.
// One access lane per thread; the lane index is the thread id.
// Assumes inputs are stable around the rising edge; reset is synchronous.
module tm_sig_detector
    import tmsig_pkg::*;
#(
    parameter hash_kind_e HASH_KIND   = HASH_BITSEL,
    parameter int         ADDR_W      = 32,
    parameter int         SIG_BITS    = 64,
    parameter int         ADDR_LSB    = 2,
    parameter int         NUM_HASH    = 4,
    parameter int         TRIE_LEAVES = 3,
    parameter logic [TRIE_LEAVES*ADDR_W-1:0] TRIE_MASK  = {32'h4, 32'h5, 32'h5},
    parameter logic [TRIE_LEAVES*ADDR_W-1:0] TRIE_MATCH = {32'h0, 32'h4, 32'h5}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NTHR-1:0]              acc_valid_i,
    input  logic [NTHR-1:0]              acc_write_i,
    input  logic [NTHR-1:0][ADDR_W-1:0]  acc_addr_i,
    input  logic [NTHR-1:0]              tx_begin_i,
    input  logic [NTHR-1:0]              tx_commit_i,
    input  logic [NTHR-1:0]              tx_abort_i,
    output logic                         conflict_o,
    output logic [TID_W-1:0]             abort_tid_o
);
    logic [NTHR-1:0]               active_w, eff_w, clear_w;
    logic [NTHR-1:0][SIG_BITS-1:0] vec_w, rd_sig_w, wr_sig_w;

    for (genvar t = 0; t < NTHR; t++) begin : g_lane
        tmsig_hash #(
            .KIND        (HASH_KIND),
            .ADDR_W      (ADDR_W),
            .SIG_BITS    (SIG_BITS),
            .ADDR_LSB    (ADDR_LSB),
            .NUM_HASH    (NUM_HASH),
            .TRIE_LEAVES (TRIE_LEAVES),
            .TRIE_MASK   (TRIE_MASK),
            .TRIE_MATCH  (TRIE_MATCH)
        ) u_hash (
            .addr_i (acc_addr_i[t]),
            .vec_o  (vec_w[t])
        );

        tmsig_thread_ctx #(
            .SIG_BITS (SIG_BITS)
        ) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (tx_begin_i[t]),
            .finish_i    (tx_commit_i[t] | tx_abort_i[t]),
            .acc_valid_i (acc_valid_i[t]),
            .acc_write_i (acc_write_i[t]),
            .vec_i       (vec_w[t]),
            .active_o    (active_w[t]),
            .eff_o       (eff_w[t]),
            .clear_o     (clear_w[t]),
            .rd_sig_o    (rd_sig_w[t]),
            .wr_sig_o    (wr_sig_w[t])
        );
    end

    tmsig_conflict #(
        .SIG_BITS (SIG_BITS)
    ) u_conflict (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_i       (eff_w),
        .write_i     (acc_write_i),
        .clear_i     (clear_w),
        .vec_i       (vec_w),
        .rd_sig_i    (rd_sig_w),
        .wr_sig_i    (wr_sig_w),
        .conflict_o  (conflict_o),
        .abort_tid_o (abort_tid_o)
    );
endmodule

// File: rtl/tm_sig_detector_chk.sv
// Property checker for tm_sig_detector, attached by bind below.
// Observes ports plus the per-thread context state.
module tm_sig_detector_chk
    import tmsig_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SIG_BITS = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NTHR-1:0]              acc_valid_i,
    input logic [NTHR-1:0]              acc_write_i,
    input logic [NTHR-1:0][ADDR_W-1:0]  acc_addr_i,
    input logic [NTHR-1:0]              tx_begin_i,
    input logic [NTHR-1:0]              tx_commit_i,
    input logic [NTHR-1:0]              tx_abort_i,
    input logic                         conflict_o,
    input logic [TID_W-1:0]             abort_tid_o,
    input logic [NTHR-1:0]              active,
    input logic [NTHR-1:0][SIG_BITS-1:0] rd_sig,
    input logic [NTHR-1:0][SIG_BITS-1:0] wr_sig
);
    logic [NTHR-1:0] clr;
    assign clr = tx_begin_i | tx_commit_i | tx_abort_i;

    AST_QUIET_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i == '0) |=> !conflict_o); // R10

    AST_READS_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_valid_i & acc_write_i) == '0 && wr_sig[0] == '0 && wr_sig[1] == '0)
        |=> !conflict_o); // R2

    AST_SAME_ADDR_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (active == 2'b11 && acc_valid_i == 2'b11 && acc_write_i == 2'b11 &&
         clr == '0 && acc_addr_i[0] == acc_addr_i[1])
        |=> (conflict_o && abort_tid_o == TID_W'(1))); // R4

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        AST_CLEAR_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            clr[t] |=> (rd_sig[t] == '0 && wr_sig[t] == '0)); // R5

        AST_IDLE_SIG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            !active[t] |-> (rd_sig[t] == '0 && wr_sig[t] == '0)); // R6

        AST_SIG_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
            (active[t] && !clr[t]) |=>
            (($past(rd_sig[t]) & ~rd_sig[t]) == '0 &&
             ($past(wr_sig[t]) & ~wr_sig[t]) == '0)); // R1
    end
endmodule

bind tm_sig_detector tm_sig_detector_chk #(
    .ADDR_W   (ADDR_W),
    .SIG_BITS (SIG_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .tx_begin_i  (tx_begin_i),
    .tx_commit_i (tx_commit_i),
    .tx_abort_i  (tx_abort_i),
    .conflict_o  (conflict_o),
    .abort_tid_o (abort_tid_o),
    .active      (active_w),
    .rd_sig      (rd_sig_w),
    .wr_sig      (wr_sig_w)
);

// File: tb/tm_sig_detector_test.sv
`timescale 1ns/1ps
// Scoreboard bench: three builds (bit-select, XOR-fold, trie) share stimulus.
// The driver task predicts each verdict from the requirements and queues it;
// the monitor pops one item per clock edge and compares all three builds.
module tm_sig_detector_test;
    import tmsig_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       acc_valid = '0, acc_write = '0;
    logic [1:0][31:0] acc_addr = '0;
    logic [1:0]       tx_b = '0, tx_c = '0, tx_x = '0;
    logic [2:0]       dut_conf;
    logic [0:0]       tid_bs, tid_xf, tid_tr;
    logic [2:0]       dut_tid;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [2:0] conf;
        logic [2:0] tid;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [63:0] m_rd[3][2];
    logic [63:0] m_wr[3][2];
    logic [1:0]  m_act;

    always #4 clk = ~clk; // 125 MHz

    tm_sig_detector #(.HASH_KIND(HASH_BITSEL)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_addr_i(acc_addr), .tx_begin_i(tx_b), .tx_commit_i(tx_c), .tx_abort_i(tx_x),
        .conflict_o(dut_conf[0]), .abort_tid_o(tid_bs));
    tm_sig_detector #(.HASH_KIND(HASH_XORFOLD)) uut_xf (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_addr_i(acc_addr), .tx_begin_i(tx_b), .tx_commit_i(tx_c), .tx_abort_i(tx_x),
        .conflict_o(dut_conf[1]), .abort_tid_o(tid_xf));
    tm_sig_detector #(.HASH_KIND(HASH_TRIE)) uut_tr (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_addr_i(acc_addr), .tx_begin_i(tx_b), .tx_commit_i(tx_c), .tx_abort_i(tx_x),
        .conflict_o(dut_conf[2]), .abort_tid_o(tid_tr));
    assign dut_tid = {tid_tr[0], tid_xf[0], tid_bs[0]};

    // Requirement-level hash of each build: R7 bit-select, R8 XOR-fold, R9 trie.
    function automatic logic [63:0] ref_hash(int kind, logic [31:0] a);
        logic [63:0] r = '0;
        if (kind == 0) begin
            r[a[7:2]] = 1'b1;
        end else if (kind == 1) begin
            for (int k = 0; k < 4; k++)
                r[k*16 + int'(a[2+4*k +: 4] ^ a[31-4*k -: 4])] = 1'b1;
        end else begin
            if (a[2]) r[a[0] ? 0 : 1] = 1'b1;
            else      r[2] = 1'b1;
        end
        return r;
    endfunction

    function automatic string hreq(int k);
        return (k == 0) ? "R7" : (k == 1) ? "R8" : "R9";
    endfunction

    // Drive one cycle, predict its verdict, queue it, advance the model.
    task automatic step(input logic [1:0] v, input logic [1:0] w,
                        input logic [31:0] a0, input logic [31:0] a1,
                        input logic [1:0] b, input logic [1:0] c,
                        input logic [1:0] x, input string tag);
        exp_t        e;
        logic [1:0]  clr, eff, f;
        logic [63:0] vt, vo;
        logic [31:0] ad[2];
        logic        hit;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr[0] = a0; acc_addr[1] = a1;
        tx_b = b; tx_c = c; tx_x = x;
        ad[0] = a0; ad[1] = a1;
        clr = b | c | x;
        for (int t = 0; t < 2; t++) eff[t] = v[t] & m_act[t] & ~clr[t];
        for (int k = 0; k < 3; k++) begin
            for (int t = 0; t < 2; t++) begin
                vt  = ref_hash(k, ad[t]);
                vo  = ref_hash(k, ad[1-t]);
                hit = 1'b0;
                if (!clr[1-t] && (vt & (w[t] ? (m_rd[k][1-t] | m_wr[k][1-t])
                                             : m_wr[k][1-t])) != '0) hit = 1'b1;
                if (eff[1-t] && (w[t] || w[1-t]) && (vt & vo) != '0) hit = 1'b1;
                f[t] = eff[t] & hit;
            end
            e.conf[k] = |f;
            e.tid[k]  = f[1];
        end
        e.tag = tag;
        sb.push_back(e);
        for (int k = 0; k < 3; k++)
            for (int t = 0; t < 2; t++) begin
                if (clr[t]) begin
                    m_rd[k][t] = '0; m_wr[k][t] = '0;
                end else if (eff[t]) begin
                    if (w[t]) m_wr[k][t] = m_wr[k][t] | ref_hash(k, ad[t]);
                    else      m_rd[k][t] = m_rd[k][t] | ref_hash(k, ad[t]);
                end
            end
        for (int t = 0; t < 2; t++)
            if (c[t] | x[t]) m_act[t] = 1'b0;
            else if (b[t])   m_act[t] = 1'b1;
    endtask

    // Monitor: pop the item for this edge and compare every build.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            for (int k = 0; k < 3; k++) begin
                n_checks++;
                if (dut_conf[k] !== e.conf[k] || (e.conf[k] && dut_tid[k] !== e.tid[k])
                    || (!e.conf[k] && dut_tid[k] !== 1'b0)) begin
                    n_fail++;
                    $display("FAIL %s %s: conflict/tid got %b/%0d expected %b/%0d",
                             e.tag, hreq(k), dut_conf[k], dut_tid[k], e.conf[k],
                             e.conf[k] ? e.tid[k] : 1'b0);
                end
            end
        end
    end

    function automatic logic [31:0] pool_addr();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0004;
            2: return 32'h0000_0008;
            3: return 32'h0000_0100;
            4: return 32'h0000_2000;
            5: return 32'h0000_0105;
            6: return 32'hF000_0004;
            default: return 32'h0000_0041;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++)
            for (int t = 0; t < 2; t++) begin
                m_rd[k][t] = '0; m_wr[k][t] = '0;
            end
        m_act = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            n_checks++;
            if (dut_conf[k] !== 1'b0 || dut_tid[k] !== 1'b0) begin
                n_fail++;
                $display("FAIL R10 reset %s: conflict/tid got %b/%0d expected 0/0",
                         hreq(k), dut_conf[k], dut_tid[k]);
            end
        end
        rst_n = 1'b1;

        step(2'b00, 2'b00, 0, 0, 2'b11, 2'b00, 2'b00, "R5 R10 begin both");
        step(2'b11, 2'b00, 32'h100, 32'h100, 0, 0, 0, "R2 read/read same cycle");
        step(2'b10, 2'b10, 0, 32'h100, 0, 0, 0, "R3 store vs other read");
        step(2'b00, 2'b00, 0, 0, 0, 0, 2'b10, "R5 abort thread 1");
        step(2'b00, 2'b00, 0, 0, 2'b10, 0, 0, "R5 restart thread 1");
        step(2'b10, 2'b00, 0, 32'h100, 0, 0, 0, "R1 R2 R5 load after clear");
        step(2'b01, 2'b01, 32'h100, 0, 0, 0, 0, "R3 store vs other load");
        step(2'b10, 2'b10, 0, 32'h2000, 0, 0, 0, "R3 R7 aliasing store");
        step(2'b01, 2'b00, 32'h2000, 0, 0, 0, 0, "R1 R3 load vs other store");
        step(2'b11, 2'b11, 32'h40, 32'h40, 0, 0, 0, "R4 same-cycle store tie");
        step(2'b11, 2'b01, 32'h44, 32'h44, 0, 0, 0, "R4 same-cycle store vs load");
        step(2'b01, 2'b01, 32'h100, 0, 0, 2'b10, 0, "R6 target ends same cycle");
        step(2'b10, 2'b10, 0, 32'h100, 0, 0, 0, "R6 access outside transaction");
        step(2'b01, 2'b01, 32'h100, 0, 0, 2'b01, 0, "R5 R6 access in own commit cycle");
        step(2'b11, 2'b11, 32'h8, 32'h8, 0, 0, 0, "R6 both outside transaction");
        step(2'b00, 2'b00, 0, 0, 2'b11, 0, 0, "R5 begin both again");
        step(2'b01, 2'b00, 32'h0, 0, 0, 0, 0, "R9 load leaf two");
        step(2'b10, 2'b10, 0, 32'h8, 0, 0, 0, "R3 R9 store same leaf");
        step(2'b01, 2'b01, 32'h105, 0, 0, 0, 0, "R8 R9 store leaf zero");
        step(2'b10, 2'b00, 0, 32'h104, 2'b00, 2'b00, 2'b00, "R8 R9 load leaf one");
        step(2'b00, 2'b00, 0, 0, 0, 2'b11, 0, "R5 commit both");

        for (int i = 0; i < 600; i++) begin
            logic [1:0] rb, rc, rx;
            for (int t = 0; t < 2; t++) begin
                rb[t] = ($urandom % 9) == 0;
                rc[t] = ($urandom % 14) == 0;
                rx[t] = ($urandom % 18) == 0;
            end
            step(2'($urandom), 2'($urandom), pool_addr(), pool_addr(), rb, rc, rx,
                 "R1 R2 R3 R4 R5 R6 mixed traffic");
        end
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, "R10 idle");
        repeat (3) @(posedge clk);
        #3;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule